// File: doc/BRIEF.md
# Per-Channel PWM Delay Aligner

This block sits between a multi-channel PWM generator and the output pins. It delays each PWM channel by its own number of high-speed clock cycles, so that the switching edges of the channels are staggered rather than coincident. The staggering reduces simultaneous supply current steps in the power stage.

Each channel's delay is formed from two settings. One is a signed per-channel trim. The other is a shared unsigned offset added to every channel. Their sum is clamped to the range 0 to 255 cycles. Software may rewrite any of these settings while audio is running. A new value is held in a shadow register and only becomes active on a PWM frame-boundary strobe, so a delay never changes in the middle of a pulse.

Top module: `pwm_delay_aligner`

## Requirements
- R1: After reset the active delays of channels 0..7 are 8, 32, 16, 48, 8, 40, 24 and 56 cycles. These come from signed trims −24, 0, −16, 16, −24, 8, −8, 24 plus a default offset of 32.
- R2: `pwm_out[c]` equals the value `pwm_in[c]` had exactly D clock cycles earlier, where D is channel c's active delay. D = 0 is a combinational pass-through in the same cycle.
- R3: The active delay is offset plus the signed trim. A negative sum gives 0.
- R4: A sum above 255 gives 255.
- R5: A write changes no active delay until a clock edge at which `frame_start` is 1. At that edge every channel takes the value computed from the settings written before it.
- R6: A write with `wr_addr` 0..7 sets the 8-bit two's-complement trim of that channel. `wr_addr` 8 sets the unsigned offset. Writes to addresses 9..15 change no delay.
- R7: A trim write affects only the addressed channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed delay clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | PWM frame-boundary strobe; loads new delays |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 4 | Setting index: 0..7 trims, 8 offset |
| wr_data | input | 8 | Setting value |
| pwm_in | input | 8 | Undelayed PWM bits, one per channel |
| pwm_out | output | 8 | Delayed PWM bits |

## Verification
A corrupted active delay shows as a shifted edge. A single input pulse reappears at the output a wrong number of cycles later, and at most 255 cycles later it is plainly visible. A broken history line loses or duplicates pulses within one delay span. A shadow value that leaks through early moves an edge before any frame strobe has been given. The bench measures the delay on all eight channels with an isolated pulse after each change, which exposes each of these failures.

// File: rtl/pda_pkg.sv
// Shared constants and helpers for the PWM delay aligner.
// Assumes at most eight channels carry non-zero default trims.
package pda_pkg;
    localparam int NUM_CH_DEF = 8;
    localparam int DLY_W_DEF  = 8;
    localparam logic [7:0] OFS_DEFAULT = 8'd32;

    // Reset trim per channel, as a signed cycle count.
    function automatic logic signed [7:0] trim_default(input int idx);
        case (idx)
            0:       return -8'sd24;
            1:       return  8'sd0;
            2:       return -8'sd16;
            3:       return  8'sd16;
            4:       return -8'sd24;
            5:       return  8'sd8;
            6:       return -8'sd8;
            7:       return  8'sd24;
            default: return  8'sd0;
        endcase
    endfunction

    // Saturated sum of an unsigned offset and a signed trim, 8-bit result.
    function automatic logic [7:0] sat_eff(input logic [7:0] ofs,
                                           input logic signed [7:0] trim);
        logic signed [9:0] sum;
        sum = $signed({2'b00, ofs}) + 10'(trim);
        if (sum < 0)
            return 8'd0;
        else if (sum > 10'sd255)
            return 8'd255;
        else
            return sum[7:0];
    endfunction
endpackage

// File: rtl/pda_sat_add.sv
// Adds an unsigned offset to a signed trim and clamps the sum to 0..2**DLY_W-1.
// Assumes both operands are DLY_W bits wide.
module pda_sat_add #(
    parameter int DLY_W = 8
) (
    input  logic [DLY_W-1:0]        ofs,
    input  logic signed [DLY_W-1:0] trim,
    output logic [DLY_W-1:0]        eff
);
    localparam int SUM_W = DLY_W + 2;
    localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((1 << DLY_W) - 1);

    logic signed [SUM_W-1:0] sum;

    // Widened signed sum, then clamp at both ends.
    always_comb begin
        sum = $signed({2'b00, ofs}) + SUM_W'(trim);
        if (sum < 0)
            eff = '0;
        else if (sum > MAX_V)
            eff = '1;
        else
            eff = sum[DLY_W-1:0];
    end
endmodule

// File: rtl/pda_regfile.sv
// Holds shadow trims and offset written by software, and loads the
// saturated active delays on each frame strobe.
// Assumes the offset lives at address NUM_CH; higher addresses are unused.
module pda_regfile #(
    parameter int NUM_CH = 8,
    parameter int DLY_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           frame_start,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DLY_W-1:0]               wr_data,
    output logic [NUM_CH-1:0][DLY_W-1:0]   eff_dly
);
    localparam logic [ADDR_W-1:0] OFS_ADDR = ADDR_W'(NUM_CH);

    logic [DLY_W-1:0]              ofs_q;
    logic [NUM_CH-1:0][DLY_W-1:0]  trim_q;
    logic [NUM_CH-1:0][DLY_W-1:0]  eff_next;

    // Shadow offset register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ofs_q <= DLY_W'(pda_pkg::OFS_DEFAULT);
        else if (wr_en && wr_addr == OFS_ADDR)
            ofs_q <= wr_data;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Shadow trim register of channel c.
        always_ff @(posedge clk) begin
            if (!rst_n)
                trim_q[c] <= DLY_W'(pda_pkg::trim_default(c));
            else if (wr_en && wr_addr == ADDR_W'(c))
                trim_q[c] <= wr_data;
        end

        pda_sat_add #(.DLY_W(DLY_W)) u_sat (
            .ofs  (ofs_q),
            .trim (trim_q[c]),
            .eff  (eff_next[c])
        );

        // Active delay of channel c, reloaded only at a frame boundary.
        always_ff @(posedge clk) begin
            if (!rst_n)
                eff_dly[c] <= DLY_W'(pda_pkg::sat_eff(pda_pkg::OFS_DEFAULT,
                                                      pda_pkg::trim_default(c)));
            else if (frame_start)
                eff_dly[c] <= eff_next[c];
        end
    end
endmodule

// File: rtl/pda_tap_line.sv
// One-bit history line with a selectable tap: output is the input SEL
// cycles ago; SEL of zero passes the input straight through.
// Assumes SEL stays below 2**DLY_W.
module pda_tap_line #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [DLY_W-1:0] sel,
    output logic             dout
);
    localparam int HIST = (1 << DLY_W) - 1;

    logic [HIST-1:0] hist;

    // Shift one new sample in per clock; bit k holds the input k+1 cycles ago.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else
            hist <= {hist[HIST-2:0], din};
    end

    // Tap selection.
    always_comb begin
        if (sel == '0)
            dout = din;
        else
            dout = hist[sel - 1'b1];
    end
endmodule

// File: rtl/pwm_delay_aligner.sv
// Top: staggers NUM_CH PWM channels by programmable per-channel delays.
// Assumes frame_start is a single-cycle strobe from the PWM generator.
module pwm_delay_aligner #(
    parameter int NUM_CH = pda_pkg::NUM_CH_DEF,
    parameter int DLY_W  = pda_pkg::DLY_W_DEF,
    parameter int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DLY_W-1:0]  wr_data,
    input  logic [NUM_CH-1:0] pwm_in,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0][DLY_W-1:0] eff_dly;

    pda_regfile #(.NUM_CH(NUM_CH), .DLY_W(DLY_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .eff_dly     (eff_dly)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_line
        pda_tap_line #(.DLY_W(DLY_W)) u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (pwm_in[c]),
            .sel   (eff_dly[c]),
            .dout  (pwm_out[c])
        );
    end
endmodule

// File: rtl/pda_checker.sv
// Property checker for the delay aligner, attached to every instance by bind.
// Assumes access to the active delay vector of the top.
module pda_checker #(
    parameter int NUM_CH = 8,
    parameter int DLY_W  = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         frame_start,
    input logic [NUM_CH-1:0]            pwm_in,
    input logic [NUM_CH-1:0]            pwm_out,
    input logic [NUM_CH-1:0][DLY_W-1:0] eff_dly
);
    // R5
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(eff_dly));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R1
        rst_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> eff_dly[c] == DLY_W'(pda_pkg::sat_eff(
                pda_pkg::OFS_DEFAULT, pda_pkg::trim_default(c))));
        // R2
        zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            eff_dly[c] == '0 |-> pwm_out[c] == pwm_in[c]);
        // R2
        one_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (eff_dly[c] == DLY_W'(1) && $past(rst_n)) |-> pwm_out[c] == $past(pwm_in[c]));
    end
endmodule

bind pwm_delay_aligner pda_checker #(.NUM_CH(NUM_CH), .DLY_W(DLY_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pwm_in      (pwm_in),
    .pwm_out     (pwm_out),
    .eff_dly     (eff_dly)
);

// File: tb/sim_pwm_delay_aligner.sv
module sim_pwm_delay_aligner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] pwm_in = '0;
    logic [7:0] pwm_out;

    int errors = 0;
    int checks = 0;
    int trim_m [8];
    int ofs_m;
    int meas [8];
    bit done = 1'b0;

    pwm_delay_aligner u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_in(pwm_in), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    // Rows: address, data, focal channel, expected delay of that channel.
    localparam int NROW = 11;
    localparam int TBL [NROW][4] = '{
        '{1, 8'h10, 1, 48},   // R3 positive trim
        '{0, 8'hE0, 0, 0},    // R3 sum exactly zero
        '{2, 8'h80, 2, 0},    // R3 clamp below zero
        '{3, 8'h7F, 3, 159},  // R3 large trim
        '{8, 200,   3, 255},  // R4 clamp above 255, R6 offset
        '{4, 8'hE8, 4, 176},  // R6 offset applies to all
        '{8, 0,     6, 0},    // R3 zero offset, negative trim
        '{7, 8'h7F, 7, 127},  // R3
        '{8, 255,   7, 255},  // R4
        '{8, 128,   2, 0},    // R3 -128 against 128
        '{6, 8'h81, 6, 1}     // R2 one-cycle delay
    };

    function automatic int exp_dly(int c);
        int s;
        s = ofs_m + trim_m[c];
        if (s < 0) return 0;
        if (s > 255) return 255;
        return s;
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic do_write(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 8) trim_m[a] = (d > 127) ? d - 256 : d;
        else if (a == 8) ofs_m = d;
    endtask

    task automatic do_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // Flush the lines, send one pulse on all channels, record arrival cycle.
    task automatic measure();
        for (int i = 0; i < 260; i++) begin
            @(negedge clk);
            pwm_in = '0;
        end
        for (int c = 0; c < 8; c++) meas[c] = -1;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            pwm_in = (k == 0) ? 8'hFF : 8'h00;
            #1;
            for (int c = 0; c < 8; c++)
                if (pwm_out[c] && meas[c] < 0) meas[c] = k;
        end
    endtask

    task automatic check_all(string req);
        measure();
        for (int c = 0; c < 8; c++) check(req, meas[c], exp_dly(c));
    endtask

    initial begin
        int rst_exp [8] = '{8, 32, 16, 48, 8, 40, 24, 56};
        int old5;
        trim_m = '{-24, 0, -16, 16, -24, 8, -8, 24};
        ofs_m = 32;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset delays
        measure();
        for (int c = 0; c < 8; c++) check("R1", meas[c], rst_exp[c]);

        // Table walk: focal check plus whole-channel check (R7 isolation)
        for (int r = 0; r < NROW; r++) begin
            do_write(TBL[r][0], TBL[r][1]);
            do_frame();
            measure();
            check("R2/R3/R4 row", meas[TBL[r][2]], TBL[r][3]);
            for (int c = 0; c < 8; c++) check("R7", meas[c], exp_dly(c));
        end

        // R5: write without a frame strobe leaves delay unchanged
        old5 = exp_dly(5);
        do_write(5, 8'h10);
        measure();
        check("R5 held", meas[5], old5);
        do_frame();
        measure();
        check("R5 loaded", meas[5], exp_dly(5));

        // R6: unused address changes nothing
        do_write(13, 8'h55);
        do_frame();
        check_all("R6");

        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 200000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule